// File: doc/BRIEF.md
# Looped Multiply-Add Memory Sequencer

This block walks a short array of 32-bit signed words held in an external synchronous RAM. For every element `x` it forms `y = a*x + (b + c)` and stores `y` at the same index in a second external RAM. The scalar coefficients `a`, `b` and `c` are 8-bit signed inputs. They are sign-extended to 32 bits, and the result wraps modulo 2^32.

A four-state controller sequences the work. The idle state waits for `start`. In that same cycle it latches the loop-invariant sum `b + c` into a register. Each element then takes three cycles. The first issues the read address and enable. The second captures the RAM's registered read data. The third computes the result and writes it out. After the last write the controller returns to idle and raises `done` for one cycle.

The surrounding logic must provide a RAM with exactly one cycle of read latency and a write port that stores on the clock edge while its enables are high.

Top module: `madd_seq`

## Requirements
- R1: After reset `done`, `src_ce`, `dst_ce` and `dst_we` are all 0.
- R2: Each element takes exactly three cycles. `src_ce` is high for one cycle, and `dst_ce`/`dst_we` are high two cycles later. No enable is high in the cycle in between.
- R3: Read addresses go 0, 1, ..., N_ELEM-1 in that order. Each write goes to the address that was read two cycles earlier.
- R4: The data word is taken from `src_rdata` in the cycle after `src_ce` was high, which is a one-cycle read latency.
- R5: `dst_wdata` equals sext(coef_a)*x + sext(off_b) + sext(off_c), truncated to the low 32 bits.
- R6: `off_b` and `off_c` are sampled only in the cycle where `start` is accepted. Changes to them later in the run have no effect, and the next run uses fresh values.
- R7: `done` is high for exactly one cycle, in the cycle after the final write, which is 3*N_ELEM cycles after the accepting edge.
- R8: `start` is ignored while a run is in progress.
- R9: While idle without `start`, no RAM enable and no `done` is asserted.
- R10: `src_ce` and `dst_ce` are never high together, and `dst_we` is high exactly when `dst_ce` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| coef_a | input | 8 | Signed multiplier coefficient |
| off_b | input | 8 | Signed first offset term |
| off_c | input | 8 | Signed second offset term |
| done | output | 1 | One-cycle pulse after the last write |
| src_addr | output | 2 | Input RAM address |
| src_ce | output | 1 | Input RAM read enable |
| src_rdata | input | 32 | Input RAM registered read data |
| dst_addr | output | 2 | Output RAM address |
| dst_ce | output | 1 | Output RAM enable |
| dst_we | output | 1 | Output RAM write enable |
| dst_wdata | output | 32 | Output RAM write data |

## Verification
Negative coefficients and values large enough to wrap are used so that a design that zero-extends, or that saturates instead of wrapping, writes the wrong words. The bench changes `off_b` and `off_c` in the middle of a run to catch a design that recomputes the sum on each iteration, and it checks that the next run uses fresh values. It pulses `start` during a run to catch a controller that restarts. It also counts cycles to `done`, so a design that captures read data one cycle early or late, or that runs an extra or missing iteration, shows up as wrong data, a wrong address order or a shifted `done`.

// File: rtl/madd_pkg.sv
package madd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_FETCH = 2'd2,
    ST_CALC  = 2'd3
  } madd_state_e;
endpackage

// File: rtl/madd_ctrl.sv
module madd_ctrl
  import madd_pkg::*;
#(
  parameter int N_ELEM = 3,
  parameter int AW     = 2,
  localparam int CW    = $clog2(N_ELEM + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output madd_state_e state_o,
  output logic [AW-1:0] rd_idx_o,
  output logic [AW-1:0] wr_idx_o,
  output logic        done_o
);
  madd_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          last;
  logic          done_d, done_q;
  logic [CW-1:0] wr_prev;

  assign last = (cnt_q == CW'(N_ELEM));

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ADDR;
      ST_ADDR:  state_d = ST_FETCH;
      ST_FETCH: state_d = ST_CALC;
      ST_CALC:  state_d = last ? ST_IDLE : ST_ADDR;
      default:  state_d = ST_IDLE;
    endcase
  end

  // iteration counter: cleared on accept, advanced on each address cycle
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (state_q == ST_IDLE && start) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (state_q == ST_ADDR) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  assign done_d = (state_q == ST_CALC) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign wr_prev  = cnt_q - CW'(1);
  assign rd_idx_o = cnt_q[AW-1:0];
  assign wr_idx_o = wr_prev[AW-1:0];
  assign state_o  = state_q;
  assign done_o   = done_q;
endmodule

// File: rtl/madd_dp.sv
module madd_dp #(
  parameter int DATA_W = 32,
  parameter int SC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sum_en,
  input  logic              x_en,
  input  logic [SC_W-1:0]   coef_a,
  input  logic [SC_W-1:0]   off_b,
  input  logic [SC_W-1:0]   off_c,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata
);
  localparam int EXT_W = DATA_W - SC_W;

  logic [DATA_W-1:0] a_ext, b_ext, c_ext;
  logic [DATA_W-1:0] sum_q, x_q;

  assign a_ext = {{EXT_W{coef_a[SC_W-1]}}, coef_a};
  assign b_ext = {{EXT_W{off_b[SC_W-1]}}, off_b};
  assign c_ext = {{EXT_W{off_c[SC_W-1]}}, off_c};

  // loop-invariant sum held for the whole run; fetched element register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      x_q   <= '0;
    end else begin
      if (sum_en) sum_q <= b_ext + c_ext;
      if (x_en)   x_q   <= rdata;
    end
  end

  assign wdata = a_ext * x_q + sum_q;
endmodule

// File: rtl/madd_seq.sv
module madd_seq
  import madd_pkg::*;
#(
  parameter int N_ELEM = 3,
  parameter int DATA_W = 32,
  parameter int SC_W   = 8,
  localparam int AW    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SC_W-1:0]   coef_a,
  input  logic [SC_W-1:0]   off_b,
  input  logic [SC_W-1:0]   off_c,
  output logic              done,
  output logic [AW-1:0]     src_addr,
  output logic              src_ce,
  input  logic [DATA_W-1:0] src_rdata,
  output logic [AW-1:0]     dst_addr,
  output logic              dst_ce,
  output logic              dst_we,
  output logic [DATA_W-1:0] dst_wdata
);
  madd_state_e state;
  logic [AW-1:0] rd_idx, wr_idx;

  madd_ctrl #(.N_ELEM(N_ELEM), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .state_o  (state),
    .rd_idx_o (rd_idx),
    .wr_idx_o (wr_idx),
    .done_o   (done)
  );

  madd_dp #(.DATA_W(DATA_W), .SC_W(SC_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .sum_en (state == ST_IDLE && start),
    .x_en   (state == ST_FETCH),
    .coef_a (coef_a),
    .off_b  (off_b),
    .off_c  (off_c),
    .rdata  (src_rdata),
    .wdata  (dst_wdata)
  );

  assign src_ce   = (state == ST_ADDR);
  assign src_addr = rd_idx;
  assign dst_ce   = (state == ST_CALC);
  assign dst_we   = (state == ST_CALC);
  assign dst_addr = wr_idx;
endmodule

// File: rtl/madd_seq_chk.sv
module madd_seq_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          src_ce,
  input logic [AW-1:0] src_addr,
  input logic          dst_ce,
  input logic          dst_we,
  input logic [AW-1:0] dst_addr
);
  assert_enable_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_ce && dst_ce));

  assert_we_with_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we == dst_ce);

  assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> $past(src_ce, 2));

  assert_read_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_ce |=> (!src_ce && !dst_ce));

  assert_addr_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (dst_addr == $past(src_addr, 2)));

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(dst_we));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!src_ce && !dst_ce));
endmodule

bind madd_seq madd_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .src_ce   (src_ce),
  .src_addr (src_addr),
  .dst_ce   (dst_ce),
  .dst_we   (dst_we),
  .dst_addr (dst_addr)
);

// File: tb/tb_madd_seq.sv
`timescale 1ns/1ps
module tb_madd_seq;
  localparam int N  = 3;
  localparam int AW = 2;

  logic clk, rst_n, start;
  logic [7:0] coef_a, off_b, off_c;
  logic done, src_ce, dst_ce, dst_we;
  logic [AW-1:0] src_addr, dst_addr;
  logic [31:0] src_rdata, dst_wdata;

  madd_seq #(.N_ELEM(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .coef_a(coef_a), .off_b(off_b), .off_c(off_c),
    .done(done), .src_addr(src_addr), .src_ce(src_ce), .src_rdata(src_rdata),
    .dst_addr(dst_addr), .dst_ce(dst_ce), .dst_we(dst_we), .dst_wdata(dst_wdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] in_mem  [N];
  logic [31:0] out_mem [N];
  int rd_n, wr_n;
  int rd_addr_log [16];
  int rd_cyc_log  [16];
  int wr_addr_log [16];
  int wr_cyc_log  [16];

  // behavioural RAMs: one-cycle registered read, edge write
  always @(posedge clk) begin
    if (src_ce) src_rdata <= in_mem[src_addr];
    if (dst_ce && dst_we) out_mem[dst_addr] <= dst_wdata;
  end

  always @(posedge clk) begin
    if (src_ce && rd_n < 16) begin
      rd_addr_log[rd_n] = int'(src_addr); rd_cyc_log[rd_n] = cyc; rd_n = rd_n + 1;
    end
    if (dst_ce && dst_we && wr_n < 16) begin
      wr_addr_log[wr_n] = int'(dst_addr); wr_cyc_log[wr_n] = cyc; wr_n = wr_n + 1;
    end
    cyc = cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_y(input byte a, input byte b, input byte c, input int x);
    return int'(a) * x + (int'(b) + int'(c));
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one full run; optional disturbance of b/c or start mid-run
  task automatic run_job(input byte a, input byte b, input byte c,
                         input int x0, input int x1, input int x2,
                         input bit disturb_bc, input bit poke_start, input string tag);
    int t0, lat, exp;
    bit seen;
    in_mem[0] = x0; in_mem[1] = x1; in_mem[2] = x2;
    for (int i = 0; i < N; i++) out_mem[i] = 32'hDEAD_BEEF;
    rd_n = 0; wr_n = 0;
    @(negedge clk);
    coef_a = a; off_b = b; off_c = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    seen = 0; lat = 0;
    for (int k = 1; k <= 40 && !seen; k++) begin
      if (k == 2 && disturb_bc) begin off_b = 8'h55; off_c = 8'h81; end
      if (k == 4 && poke_start) start = 1'b1;
      if (k == 5 && poke_start) start = 1'b0;
      @(negedge clk);
      if (done) begin seen = 1; lat = cyc - t0; end
    end
    chk(seen && lat == 3*N, {"R7 done latency ", tag}, lat, 3*N);
    @(negedge clk);
    chk(done == 1'b0, {"R7 done one cycle ", tag}, done, 0);
    chk(rd_n == N, {"R8 read count ", tag}, rd_n, N);
    chk(wr_n == N, {"R8 write count ", tag}, wr_n, N);
    for (int i = 0; i < N && i < rd_n && i < wr_n; i++) begin
      chk(rd_addr_log[i] == i, {"R3 read order ", tag}, rd_addr_log[i], i);
      chk(wr_addr_log[i] == i, {"R3 write addr ", tag}, wr_addr_log[i], i);
      chk(wr_cyc_log[i] - rd_cyc_log[i] == 2, {"R2 read-to-write gap ", tag},
          wr_cyc_log[i] - rd_cyc_log[i], 2);
      if (i > 0)
        chk(rd_cyc_log[i] - rd_cyc_log[i-1] == 3, {"R2 iteration period ", tag},
            rd_cyc_log[i] - rd_cyc_log[i-1], 3);
    end
    for (int i = 0; i < N; i++) begin
      exp = exp_y(a, b, c, int'(in_mem[i]));
      chk(out_mem[i] == exp, {"R4 R5 R6 result ", tag}, int'(out_mem[i]), exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; coef_a = '0; off_b = '0; off_c = '0;
    repeat (3) @(negedge clk);
    chk(!done && !src_ce && !dst_ce && !dst_we, "R1 reset outputs",
        {done, src_ce, dst_ce, dst_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !src_ce && !dst_ce, "R1 after release", {done, src_ce, dst_ce}, 0);
  endtask

  task automatic t_idle();
    int w0, r0;
    bit busy;
    w0 = wr_n; r0 = rd_n; busy = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (src_ce || dst_ce || dst_we || done) busy = 1;
    end
    chk(!busy && wr_n == w0 && rd_n == r0, "R9 idle without start", busy, 0);
  endtask

  initial begin
    rd_n = 0; wr_n = 0;
    t_reset();
    t_idle();
    run_job(8'sd3, 8'sd5, 8'sd7, 10, 20, 30, 0, 0, "basic");
    run_job(-8'sd128, 8'sd127, -8'sd1, 32'h7FFF_FFFF, -100, 32'h0100_0000, 0, 0, "wrap");
    run_job(-8'sd7, -8'sd20, 8'sd9, 1234, -5, 0, 1, 0, "bc_change");
    run_job(8'sd2, 8'sd100, 8'sd100, 1, 2, 3, 0, 0, "fresh_bc");
    run_job(8'sd11, 8'sd1, 8'sd2, 99, 98, 97, 0, 1, "start_busy");
    t_idle();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule